// File: doc/BRIEF.md
# Terminated Rate-Half Convolutional Encoder

This block turns a serial message into a rate-1/2 convolutional code. Each accepted message bit goes into a short shift memory. Two parity bits are formed from the new bit and the stored bits, using two tap masks set by parameters. The first parity bit comes from mask A and the second from mask B. Both go out together as one 2-bit code symbol. The default masks give a constraint-length-3 code with taps 111 and 101. The same RTL also builds a constraint-length-9 code with eight memory cells.

Message boundaries are marked on the input by a start flag and an end flag. A start flag empties the memory before its bit is coded, so a new frame does not depend on an earlier unfinished one. After the bit that carries the end flag, the encoder adds one zero bit for each memory cell, with no help from the source. During that flush it does not accept input. The memory is all zero when the flush ends. The last flush symbol carries an end marker on the output. An S-bit frame therefore gives S + MEM_CELLS symbols, which is 2(S + MEM_CELLS) code bits.

Both data paths are valid/ready streams. An input bit is taken on a cycle when `in_valid` and `in_ready` are both high. A symbol leaves on a cycle when `out_valid` and `out_ready` are both high. The output holds one registered symbol. While the sink stalls, that symbol and its marker stay unchanged. `in_ready` stays low until the output slot is free, so no symbol is lost or sent twice.

Top module: `conv_stream_enc`

## Requirements
- R1: With the default masks, `out_sym[1]` = new ^ prev ^ oldest and `out_sym[0]` = new ^ oldest, where "new" is the bit being coded and "prev"/"oldest" are the two stored bits.
- R2: While reset is low and after it is released, `out_valid` is 0 and the memory is all zero; `in_ready` is 1 once reset is released.
- R3: A bit accepted with `in_first` = 1 is coded as if the memory held zeros, whatever earlier bits left in it.
- R4: After a bit accepted with `in_last` = 1, exactly MEM_CELLS further symbols are produced, each coded from a zero input bit, so an S-bit frame yields S + MEM_CELLS symbols.
- R5: `in_ready` is 0 from the cycle after the end-flagged bit is accepted until the final flush symbol has been loaded into the output register.
- R6: `out_last` is 1 only on the final flush symbol of a frame and 0 on all other symbols.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_sym` and `out_last` hold their values and `out_valid` stays 1; every symbol is delivered exactly once and in order.
- R8: Outside a flush, `in_ready` equals (not `out_valid`) or `out_ready`; an input bit is never accepted while the output slot is full and stalled.
- R9: With MEM_CELLS = 8 and masks 111101011 / 101110001, a 16-bit frame produces 24 symbols, and the first symbol of a frame whose first bit is 1 is 11.
- R10: With the default code, frame 1,0,0,1,1 produces the symbols 11, 10, 11, 11, 01, 01, 11 (written `out_sym[1]` then `out_sym[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Message bit offered |
| in_ready | output | 1 | Encoder can take a message bit this cycle |
| in_bit | input | 1 | Message bit |
| in_first | input | 1 | Bit opens a frame; memory is treated as zero |
| in_last | input | 1 | Bit closes a frame; flush follows |
| out_valid | output | 1 | Code symbol present |
| out_ready | input | 1 | Sink takes the symbol this cycle |
| out_sym | output | 2 | Code symbol: bit 1 from mask A, bit 0 from mask B |
| out_last | output | 1 | Symbol is the final flush symbol of its frame |

## Verification
The bench targets four things. The first is the flush: a design that produces the wrong number of zero-input symbols, or marks the wrong one as last, would put the end marker out of step with the reference. The second is a frame restarted with `in_first` before the previous frame's end flag. A design that keeps the old memory would code the first symbols of the new frame wrongly. Long stretches of random back-pressure check that the input is held off exactly while the output slot is full or a flush is running. A design that drops or repeats a stalled symbol would shift the whole rest of the stream. The two published sequences are checked symbol by symbol on the short code and by length on the long one.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  typedef enum logic {
    PH_MSG   = 1'b0,
    PH_FLUSH = 1'b1
  } enc_phase_e;

  typedef struct packed {
    logic par_a;
    logic par_b;
  } code_pair_t;

endpackage

// File: rtl/conv_shift_mem.sv
module conv_shift_mem #(
  parameter int MEM_CELLS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 restart,
  input  logic                 din,
  output logic [MEM_CELLS-1:0] mem_eff
);

  logic [MEM_CELLS-1:0] mem_q;
  logic [MEM_CELLS-1:0] mem_d;

  // restart makes the current bit see an empty memory
  assign mem_eff = restart ? '0 : mem_q;

  generate
    if (MEM_CELLS == 1) begin : g_single
      assign mem_d = din;
    end else begin : g_multi
      assign mem_d = {din, mem_eff[MEM_CELLS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (adv) begin
      mem_q <= mem_d;
    end
  end

endmodule

// File: rtl/conv_parity.sv
module conv_parity
  import conv_enc_pkg::*;
#(
  parameter int             KLEN  = 3,
  parameter logic [KLEN-1:0] GEN_A = 3'b111,
  parameter logic [KLEN-1:0] GEN_B = 3'b101
) (
  input  logic [KLEN-1:0] window,
  output code_pair_t      pair
);

  // window[KLEN-1] is the newest bit, matching the leftmost tap
  logic [KLEN-1:0] term_a;
  logic [KLEN-1:0] term_b;

  generate
    for (genvar t = 0; t < KLEN; t++) begin : g_tap
      assign term_a[t] = window[t] & GEN_A[t];
      assign term_b[t] = window[t] & GEN_B[t];
    end
  endgenerate

  assign pair.par_a = ^term_a;
  assign pair.par_b = ^term_b;

endmodule

// File: rtl/conv_flush_ctrl.sv
module conv_flush_ctrl
  import conv_enc_pkg::*;
#(
  parameter int MEM_CELLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_free,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic msg_go,
  output logic tail_go,
  output logic tail_final
);

  localparam int CW = $clog2(MEM_CELLS + 1);

  enc_phase_e    phase_q;
  logic [CW-1:0] left_q;

  assign in_ready   = slot_free && (phase_q == PH_MSG);
  assign msg_go     = in_valid && in_ready;
  assign tail_go    = slot_free && (phase_q == PH_FLUSH);
  assign tail_final = tail_go && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MSG;
      left_q  <= '0;
    end else if (msg_go && in_last) begin
      phase_q <= PH_FLUSH;
      left_q  <= CW'(MEM_CELLS);
    end else if (tail_go) begin
      left_q <= left_q - CW'(1);
      if (tail_final) begin
        phase_q <= PH_MSG;
      end
    end
  end

endmodule

// File: rtl/conv_out_stage.sv
module conv_out_stage
  import conv_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  code_pair_t pair,
  input  logic       last,
  input  logic       out_ready,
  output logic       slot_free,
  output logic       out_valid,
  output logic [1:0] out_sym,
  output logic       out_last
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_sym   <= {pair.par_a, pair.par_b};
      out_last  <= last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_stream_enc.sv
module conv_stream_enc
  import conv_enc_pkg::*;
#(
  parameter int                 MEM_CELLS = 2,
  parameter logic [MEM_CELLS:0] GEN_A     = 3'b111,
  parameter logic [MEM_CELLS:0] GEN_B     = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_first,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_sym,
  output logic       out_last
);

  localparam int KLEN = MEM_CELLS + 1;

  logic                 slot_free;
  logic                 msg_go;
  logic                 tail_go;
  logic                 tail_final;
  logic                 din;
  logic [MEM_CELLS-1:0] mem_eff;
  logic [KLEN-1:0]      window;
  code_pair_t           pair;

  conv_flush_ctrl #(.MEM_CELLS(MEM_CELLS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_free  (slot_free),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .msg_go     (msg_go),
    .tail_go    (tail_go),
    .tail_final (tail_final)
  );

  // flush cycles feed zeros
  assign din = tail_go ? 1'b0 : in_bit;

  conv_shift_mem #(.MEM_CELLS(MEM_CELLS)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (msg_go || tail_go),
    .restart (msg_go && in_first),
    .din     (din),
    .mem_eff (mem_eff)
  );

  assign window = {din, mem_eff};

  conv_parity #(.KLEN(KLEN), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_par (
    .window (window),
    .pair   (pair)
  );

  conv_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (msg_go || tail_go),
    .pair      (pair),
    .last      (tail_final),
    .out_ready (out_ready),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .out_last  (out_last)
  );

endmodule

// File: rtl/conv_stream_enc_chk.sv
module conv_stream_enc_chk #(
  parameter int MEM_CELLS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_sym,
  input logic       out_last
);

  logic        frame_open;
  logic [15:0] sent_since;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_open <= 1'b0;
      sent_since <= '0;
    end else begin
      if (out_fire && frame_open) begin
        sent_since <= sent_since + 16'd1;
      end
      if (out_fire && out_last) begin
        frame_open <= 1'b0;
      end
      if (in_fire && in_last) begin
        frame_open <= 1'b1;
        sent_since <= '0;
      end
    end
  end

  // R8: a bit is only taken when the output slot can receive its symbol
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (!out_valid || out_ready));

  // R7: stalled symbol is held
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last)));

  // R5: no input while flush symbols are still owed
  p_flush_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_open && !(out_valid && out_last)) |-> !in_ready);

  // R6: end marker only after an end-flagged bit
  p_last_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |-> frame_open);

  // R4: end marker arrives after the message symbol plus MEM_CELLS-1 flush symbols
  p_flush_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |-> (sent_since == 16'(MEM_CELLS)));

endmodule

bind conv_stream_enc conv_stream_enc_chk #(.MEM_CELLS(MEM_CELLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sym   (out_sym),
  .out_last  (out_last)
);

// File: tb/tb_conv_stream_enc.sv
module tb_conv_stream_enc;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       iv [2];
  logic       ib [2];
  logic       ifs[2];
  logic       ilt[2];
  logic       ir [2];
  logic       ov [2];
  logic       ordy[2];
  logic [1:0] os [2];
  logic       ol [2];

  conv_stream_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]), .in_bit(ib[0]),
    .in_first(ifs[0]), .in_last(ilt[0]), .out_valid(ov[0]), .out_ready(ordy[0]),
    .out_sym(os[0]), .out_last(ol[0])
  );

  conv_stream_enc #(.MEM_CELLS(8), .GEN_A(9'b111101011), .GEN_B(9'b101110001)) dut9 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]), .in_bit(ib[1]),
    .in_first(ifs[1]), .in_last(ilt[1]), .out_valid(ov[1]), .out_ready(ordy[1]),
    .out_sym(os[1]), .out_last(ol[1])
  );

  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc   = 0;
  int         gate_pct = 100;
  int         rdy_pct  = 100;
  int         memc[2]  = '{2, 8};
  logic [8:0] gen_a[2] = '{9'b000000111, 9'b111101011};
  logic [8:0] gen_b[2] = '{9'b000000101, 9'b101110001};
  logic [8:0] st[2];
  logic       held[2];
  logic [2:0] bq[2][$];   // {bit, first, last}
  logic [2:0] eq[2][$];   // {last, sym}
  logic [1:0] cap[2][$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [1:0] enc(input int d, input logic [8:0] win);
    return {^(win & gen_a[d]), ^(win & gen_b[d])};
  endfunction

  task automatic model_accept(input int d, input logic b, input logic f, input logic l);
    logic [8:0] win;
    if (f) st[d] = '0;
    win = ({8'b0, b} << memc[d]) | st[d];
    eq[d].push_back({1'b0, enc(d, win)});
    st[d] = win >> 1;
    if (l) begin
      for (int t = 1; t <= memc[d]; t++) begin
        win = st[d];
        eq[d].push_back({(t == memc[d]), enc(d, win)});
        st[d] = win >> 1;
      end
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    logic [2:0] x;
    logic [2:0] e;
    int         unl;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      if (!held[d]) begin
        if (bq[d].size() > 0 && ($urandom % 100) < gate_pct) begin
          x = bq[d].pop_front();
          iv[d] = 1'b1; ib[d] = x[2]; ifs[d] = x[1]; ilt[d] = x[0];
          held[d] = 1'b1;
        end else begin
          iv[d] = 1'b0; ib[d] = 1'($urandom); ifs[d] = 1'($urandom); ilt[d] = 1'($urandom);
        end
      end
      ordy[d] = (($urandom % 100) < rdy_pct);
    end
    #1;
    for (int d = 0; d < 2; d++) begin
      // R5 / R8: ready expected from owed flush symbols and slot state
      unl = eq[d].size() - (ov[d] ? 1 : 0);
      check("R5/R8 in_ready", ir[d], (unl == 0) && (!ov[d] || ordy[d]));
      if (ov[d] && ordy[d]) begin
        if (eq[d].size() == 0) begin
          check("R7 unexpected symbol", 1, 0);
        end else begin
          e = eq[d].pop_front();
          check("R1/R6/R7 symbol+last", {ol[d], os[d]}, e);
        end
        cap[d].push_back(os[d]);
      end
      if (iv[d] && ir[d]) begin
        model_accept(d, ib[d], ifs[d], ilt[d]);
        held[d] = 1'b0;
      end
    end
    cyc++;
    if (cyc > WD_LIMIT) begin
      check("watchdog", 1, 0);
      finish_run();
    end
  endtask

  task automatic drain(input int rp);
    int guard = 0;
    gate_pct = 100;
    rdy_pct  = rp;
    while ((bq[0].size() + bq[1].size() + eq[0].size() + eq[1].size()) != 0 ||
           held[0] || held[1]) begin
      step();
      guard++;
      if (guard > 5000) begin
        check("drain stuck", 1, 0);
        return;
      end
    end
    step();
  endtask

  task automatic push_frame(input int d, input logic [31:0] bits, input int len, input bit closed);
    for (int i = len - 1; i >= 0; i--) begin
      bq[d].push_back({bits[i], (i == len - 1), (closed && i == 0)});
    end
  endtask

  logic [1:0] ref10[7] = '{2'b11, 2'b10, 2'b11, 2'b11, 2'b01, 2'b01, 2'b11};
  logic [1:0] refab[6] = '{2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b11};

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++) begin
      iv[d] = 0; ib[d] = 0; ifs[d] = 0; ilt[d] = 0; ordy[d] = 0;
      held[d] = 0; st[d] = '0;
    end
    repeat (3) @(negedge clk);
    check("R2 out_valid in reset", ov[0], 0);
    check("R2 out_valid in reset (long code)", ov[1], 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 out_valid after reset", ov[0], 0);
    check("R2 in_ready after reset", ir[0], 1);

    // R10 short code vector; R9 long code 16-bit frame
    push_frame(0, 32'b10011, 5, 1'b1);
    push_frame(1, 32'b1010000100000101, 16, 1'b1);
    drain(100);
    check("R10/R4 symbol count", cap[0].size(), 7);
    for (int i = 0; i < 7 && i < cap[0].size(); i++) check("R10 pair", cap[0][i], ref10[i]);
    check("R9/R4 long code count", cap[1].size(), 24);
    if (cap[1].size() > 0) check("R9 first pair", cap[1][0], 2'b11);
    cap[0].delete(); cap[1].delete();

    // R3 restart mid-frame: 1,1 unclosed then new frame 0,1
    push_frame(0, 32'b11, 2, 1'b0);
    push_frame(0, 32'b01, 2, 1'b1);
    drain(100);
    check("R3 count", cap[0].size(), 6);
    for (int i = 0; i < 6 && i < cap[0].size(); i++) check("R3 restart pair", cap[0][i], refab[i]);
    cap[0].delete(); cap[1].delete();

    // R7 back-pressure on the known vector
    push_frame(0, 32'b10011, 5, 1'b1);
    drain(30);
    check("R7 stalled count", cap[0].size(), 7);
    for (int i = 0; i < 7 && i < cap[0].size(); i++) check("R7 stalled pair", cap[0][i], ref10[i]);
    cap[0].delete(); cap[1].delete();

    // random frames, some left unclosed (R3), random stalls (R7)
    gate_pct = 70;
    rdy_pct  = 60;
    for (int n = 0; n < 4000; n++) begin
      for (int d = 0; d < 2; d++) begin
        if (bq[d].size() < 3) begin
          int len = 1 + ($urandom % 12);
          push_frame(d, $urandom, len, (($urandom % 8) != 0));
        end
      end
      if (n % 500 == 0) rdy_pct = 20 + ($urandom % 80);
      step();
    end
    for (int d = 0; d < 2; d++) bq[d].push_back({1'b0, 1'b1, 1'b1});
    drain(100);
    check("R4 all expected symbols delivered", eq[0].size() + eq[1].size(), 0);
    finish_run();
  end

endmodule